// File: doc/BRIEF.md
# Uncorrectable Error Logger with First-Error Pointer

This block gathers uncorrectable error events from a data-movement engine. Each error source drives a one-cycle pulse. The pulse sets a sticky status bit for that source. Software clears a status bit by writing 1 to it. A mask bit per source keeps that source away from the pointer and from both summary outputs, but the status bit still records the event. A severity bit per source marks the error as fatal (1) or non-fatal (0). The severity register also holds a separate multiple-errors flag that software can read and write.

A pointer register records the index of the first unmasked error that was logged, and then freezes. It stays frozen until software clears the status bit it points to. Clearing other bits does not release it. Once released, the pointer loads again from the lowest-numbered unmasked status bit that is still set, or from the next unmasked error to arrive.

Software reaches the block through a small register port. A write takes effect at the clock edge. A read is combinational and follows the address.

Top module: `uncorr_err_log`

## Requirements
- R1: An error pulse on `errIn[i]` sets status bit i at the same clock edge. The bit stays set until software clears it, even if no further pulse arrives.
- R2: A write to address 0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. If a clear and an error pulse hit the same bit in the same cycle, the bit stays set.
- R3: The mask register is at address 1, bits [7:0], and resets to 0. A set mask bit still lets its error set the status bit. It never loads the pointer and never drives `fatalErr` or `nonFatalErr`.
- R4: When the pointer is armed, the first unmasked error loads the pointer at the edge that sets its status bit. If several unmasked errors arrive together, the pointer takes the lowest index. Address 3 reads the pointer in bits [4:0] and the valid flag in bit 5.
- R5: While the status bit it points to stays set, the pointer holds its value. Later errors on other sources do not change it.
- R6: `firstPtrValid` is 1 only while the pointed-to status bit is set and unmasked. Masking that source drops the flag, and unmasking it raises the flag again.
- R7: When the pointed-to status bit is cleared, `firstPtrValid` is low for exactly one cycle. At the next edge the pointer reloads with the lowest-numbered unmasked status bit still set, if there is one.
- R8: The severity register is at address 2. Bits [7:0] are the per-source severity bits and reset to 0x06: bit 0 (poisoned data) = 0, bit 1 (internal parity) = 1, bit 2 (read-completion header) = 1, bit 3 (read-address decode) = 0, and bits 4 to 7 = 0. Bit 8 is the multiple-errors flag. It resets to 0, and software can write it and read it back.
- R9: `fatalErr` is the OR of the status bits that are unmasked and have severity 1. `nonFatalErr` is the OR of the status bits that are unmasked and have severity 0.
- R10: After reset, the status is 0 and `firstPtrValid`, `fatalErr` and `nonFatalErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errIn | input | NUM_SRC | One-cycle error pulses, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 status, 1 mask, 2 severity, 3 pointer |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational read data for `regAddr` |
| errStatus | output | NUM_SRC | Sticky status vector |
| firstPtr | output | PTR_W | Index of the first logged unmasked error |
| firstPtrValid | output | 1 | The pointer names a set, unmasked status bit |
| fatalErr | output | 1 | Some unmasked error with severity 1 is pending |
| nonFatalErr | output | 1 | Some unmasked error with severity 0 is pending |

## Verification
The bench builds the block with its defaults: eight sources, a 5-bit pointer and a 16-bit register word. With only eight sources, every non-zero pattern of simultaneous error pulses (all 255 of them) can be applied. For each pattern the bench computes the expected lowest index and the fatal and non-fatal outputs arithmetically, using the default severity. Single-source sweeps with and without masking cover each source on its own. Directed sequences cover the following cases:
- the pointer freezing while other errors arrive;
- the one-cycle gap in `firstPtrValid` when the pointer rearms and reloads;
- masking a source after it has been captured;
- a clear and an error pulse on the same bit in the same cycle.

// File: rtl/uel_pkg.sv
package uel_pkg;
  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic wrSev;
  } uel_strobe_t;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_SEV    = 2'd2;
  localparam logic [1:0] ADDR_PTR    = 2'd3;
endpackage

// File: rtl/uel_ctrl.sv
module uel_ctrl
  import uel_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PTR_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic [NUM_SRC-1:0] statusQ,
  input  logic [NUM_SRC-1:0] maskQ,
  output uel_strobe_t        strobe,
  output logic [PTR_W-1:0]   ptrQ,
  output logic               ptrValid
);
  logic heldQ;
  logic armed;
  logic [NUM_SRC-1:0] cand;

  function automatic logic bitAt(input logic [NUM_SRC-1:0] v, input logic [PTR_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) if (idx == PTR_W'(i)) r = v[i];
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] lowestIdx(input logic [NUM_SRC-1:0] v);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) if (v[i]) r = PTR_W'(i);
    return r;
  endfunction

  always_comb begin
    strobe.wrStatus = regWrEn && (regAddr == ADDR_STATUS);
    strobe.wrMask   = regWrEn && (regAddr == ADDR_MASK);
    strobe.wrSev    = regWrEn && (regAddr == ADDR_SEV);
  end

  // Armed when nothing is held, or when the held bit has been cleared
  assign armed    = !heldQ || !bitAt(statusQ, ptrQ);
  assign cand     = (statusQ | errIn) & ~maskQ;
  assign ptrValid = heldQ && bitAt(statusQ, ptrQ) && !bitAt(maskQ, ptrQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ <= 1'b0;
      ptrQ  <= '0;
    end else if (armed) begin
      heldQ <= |cand;
      if (|cand) ptrQ <= lowestIdx(cand);
    end
  end

  assert_ptr_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (heldQ && bitAt(statusQ, ptrQ)) |=> (heldQ && $stable(ptrQ)));

  assert_masked_no_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (heldQ && (!$past(heldQ) || ($past(ptrQ) != ptrQ))) |-> !bitAt($past(maskQ), ptrQ));
endmodule

// File: rtl/uel_datapath.sv
module uel_datapath
  import uel_pkg::*;
#(
  parameter int               NUM_SRC   = 8,
  parameter int               DATA_W    = 16,
  parameter int               PTR_W     = 5,
  parameter logic [NUM_SRC-1:0] SEV_RESET = 8'h06
) (
  input  logic               clk,
  input  logic               rstN,
  input  uel_strobe_t        strobe,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic [PTR_W-1:0]   ptrQ,
  input  logic               ptrValid,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  regRdData,
  output logic               fatalErr,
  output logic               nonFatalErr
);
  localparam int MULTI_BIT = NUM_SRC;
  localparam int VALID_BIT = PTR_W;

  logic [NUM_SRC-1:0] statusD, maskD, sevD, sevQ, live;
  logic multiQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // An error pulse wins over a clear in the same cycle
    assign statusD[i] = errIn[i] | (statusQ[i] & ~(strobe.wrStatus & regWrData[i]));
    assign maskD[i]   = strobe.wrMask ? regWrData[i] : maskQ[i];
    assign sevD[i]    = strobe.wrSev  ? regWrData[i] : sevQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      sevQ    <= SEV_RESET;
      multiQ  <= 1'b0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      sevQ    <= sevD;
      if (strobe.wrSev) multiQ <= regWrData[MULTI_BIT];
    end
  end

  assign live        = statusQ & ~maskQ;
  assign fatalErr    = |(live & sevQ);
  assign nonFatalErr = |(live & ~sevQ);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_STATUS: regRdData[NUM_SRC-1:0] = statusQ;
      ADDR_MASK:   regRdData[NUM_SRC-1:0] = maskQ;
      ADDR_SEV: begin
        regRdData[NUM_SRC-1:0] = sevQ;
        regRdData[MULTI_BIT]   = multiQ;
      end
      default: begin
        regRdData[PTR_W-1:0] = ptrQ;
        regRdData[VALID_BIT] = ptrValid;
      end
    endcase
  end

  assert_err_sets_status_R1: assert property (@(posedge clk) disable iff (!rstN)
    (errIn != '0) |=> ((statusQ & $past(errIn)) == $past(errIn)));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStatus |=> ((statusQ & $past(regWrData[NUM_SRC-1:0] & ~errIn)) == '0));
endmodule

// File: rtl/uncorr_err_log.sv
module uncorr_err_log
  import uel_pkg::*;
#(
  parameter int               NUM_SRC   = 8,
  parameter int               PTR_W     = 5,
  parameter int               DATA_W    = 16,
  parameter logic [NUM_SRC-1:0] SEV_RESET = 8'h06
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_SRC-1:0] errStatus,
  output logic [PTR_W-1:0]   firstPtr,
  output logic               firstPtrValid,
  output logic               fatalErr,
  output logic               nonFatalErr
);
  uel_strobe_t        strobe;
  logic [NUM_SRC-1:0] maskQ;

  uel_ctrl #(.NUM_SRC(NUM_SRC), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .errIn(errIn), .statusQ(errStatus), .maskQ(maskQ),
    .strobe(strobe), .ptrQ(firstPtr), .ptrValid(firstPtrValid)
  );

  uel_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PTR_W(PTR_W), .SEV_RESET(SEV_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .errIn(errIn), .ptrQ(firstPtr), .ptrValid(firstPtrValid),
    .statusQ(errStatus), .maskQ(maskQ), .regRdData(regRdData),
    .fatalErr(fatalErr), .nonFatalErr(nonFatalErr)
  );
endmodule

// File: tb/uncorr_err_log_test.sv
`timescale 1ns/1ps
module uncorr_err_log_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  errIn = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  errStatus;
  logic [4:0]  firstPtr;
  logic        firstPtrValid, fatalErr, nonFatalErr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uncorr_err_log uut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .errStatus(errStatus),
    .firstPtr(firstPtr), .firstPtrValid(firstPtrValid),
    .fatalErr(fatalErr), .nonFatalErr(nonFatalErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [7:0] p);
    errIn = p;
    @(negedge clk);
    errIn = '0;
  endtask

  task automatic clearAll();
    wr(2'd0, 16'h00FF);
    @(negedge clk);
  endtask

  function automatic int lowest(input int p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 status", errStatus, 8'h00);
    chk("R10 valid", firstPtrValid, 1'b0);
    chk("R10 summaries", {fatalErr, nonFatalErr}, 2'b00);
    rd(2'd2, d); chk("R8 severity reset", d, 16'h0006);
    rd(2'd1, d); chk("R3 mask reset", d, 16'h0000);

    // Single-source sweep
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      chk("R1 single status", errStatus, 32'(1 << i));
      rd(2'd3, d); chk("R4 single pointer", d, 32'(32 + i));
      chk("R9 single fatal", fatalErr, (i == 1 || i == 2) ? 1 : 0);
      chk("R9 single nonfatal", nonFatalErr, (i == 1 || i == 2) ? 0 : 1);
      clearAll();
      chk("R7 cleared valid", firstPtrValid, 1'b0);
    end

    // Masked single-source sweep
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, 16'(1 << i));
      pulse(8'(1 << i));
      chk("R3 masked status", errStatus, 32'(1 << i));
      chk("R3 masked no pointer", firstPtrValid, 1'b0);
      chk("R3 masked summaries", {fatalErr, nonFatalErr}, 2'b00);
      clearAll();
      wr(2'd1, 16'h0000);
    end

    // Exhaustive simultaneous patterns
    for (int p = 1; p < 256; p++) begin
      pulse(8'(p));
      rd(2'd3, d); chk("R4 lowest of pattern", d, 32'(32 + lowest(p)));
      chk("R9 pattern fatal", fatalErr, ((p & 6) != 0) ? 1 : 0);
      chk("R9 pattern nonfatal", nonFatalErr, ((p & 8'hF9) != 0) ? 1 : 0);
      clearAll();
    end

    // Freeze and rearm
    pulse(8'h20);
    pulse(8'h04);
    rd(2'd3, d); chk("R5 frozen pointer", d, 16'h0025);
    wr(2'd0, 16'h0020);
    chk("R2 partial clear", errStatus, 8'h04);
    chk("R7 gap cycle", firstPtrValid, 1'b0);
    @(negedge clk);
    rd(2'd3, d); chk("R7 reload lowest pending", d, 16'h0022);
    wr(2'd0, 16'h0001);
    rd(2'd3, d); chk("R5 other clear no release", d, 16'h0022);
    clearAll();

    // Masking after capture
    pulse(8'h10);
    wr(2'd1, 16'h0010);
    rd(2'd3, d); chk("R6 masked after capture", d, 16'h0004);
    wr(2'd1, 16'h0000);
    rd(2'd3, d); chk("R6 unmasked again", d, 16'h0024);
    clearAll();

    // Set beats clear, zero bits ignored
    pulse(8'h48);
    errIn = 8'h08;
    wr(2'd0, 16'h00FF);
    errIn = '0;
    chk("R2 set wins", errStatus, 8'h08);
    clearAll();
    pulse(8'h81);
    wr(2'd0, 16'h0000);
    chk("R2 zero write", errStatus, 8'h81);
    repeat (5) @(negedge clk);
    chk("R1 sticky", errStatus, 8'h81);
    clearAll();

    // Severity programming
    wr(2'd2, 16'h01F0);
    rd(2'd2, d); chk("R8 severity readback", d, 16'h01F0);
    pulse(8'h01);
    chk("R9 programmed nonfatal", {fatalErr, nonFatalErr}, 2'b01);
    pulse(8'h80);
    chk("R9 programmed fatal", {fatalErr, nonFatalErr}, 2'b11);
    wr(2'd1, 16'h0001);
    chk("R3 mask drops nonfatal", {fatalErr, nonFatalErr}, 2'b10);
    clearAll();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule